// File: doc/BRIEF.md
# Prefix-Steered Effective Address Generator

This block forms the 16-bit effective address of one operand for an 8-bit core. Up to two address bytes follow each opcode, and prefix bytes in the opcode stream can change how they are read. The block watches every fetched opcode byte. Three prefix codes are recognised and held for the next instruction. One swaps the X index register for Y. One adds a memory-indirect step. The third does both.

When the sequencer pulses `start` with a mode code and the address bytes, the block does its work in three steps. It first performs any pointer fetch through a byte read port that uses a valid/ready handshake. It then adds the selected index register. Finally it presents the result on `eaOut` with a one-cycle `eaDone` strobe. After that strobe the held prefix is dropped. The `idxSwap` output tells the rest of the core that implicit X uses of the coming instruction refer to Y.

Top module: `prefixEaGen`

## Requirements
- R1: After reset `busy`, `eaDone` and `rdValid` are 0, and `idxSwap` is 0 (no prefix held).
- R2: With no prefix held, the mode code on `mode` selects the address, with no read: 0 gives {0x00, addrLo}, 1 gives {addrHi, addrLo}, 2 gives the index alone, 3 gives index + addrLo, 4 gives index + {addrHi, addrLo}, and 5 to 7 act as code 0. `eaDone` rises in the first cycle after `start` is taken.
- R3: Mode 3 forms the full 9-bit sum, so 0xFF + 0xFF gives 0x01FE. Mode 4 wraps modulo 65536.
- R4: Opcode byte 0x90 makes the index Y instead of X and raises `idxSwap` from the cycle after that byte.
- R5: Opcode byte 0x92 makes modes 0 and 3 read one byte at address addrLo. That byte becomes the low address byte, the high byte is 0x00, and indexing then applies as in R2.
- R6: Under indirection, modes 1 and 4 read a word pointer. The first read is at addrLo and gives the high byte. The second read is at addrLo+1, wrapping within 8 bits, and gives the low byte. The pointer then replaces {addrHi, addrLo}.
- R7: Opcode byte 0x91 gives both the Y substitution of R4 and the indirection of R5/R6.
- R8: A prefix byte replaces a prefix already held; the two do not combine.
- R9: The held prefix is cleared in the cycle after `eaDone`, so the next instruction uses X and direct addressing.
- R10: A read request holds `rdValid` and a stable `rdAddr` until `rdReady`. Data on `rdData` is taken in the cycle where both are 1.
- R11: `eaDone` lasts exactly one cycle, `busy` is 1 from the cycle after `start` is taken until `eaDone` has been shown, and `start` is ignored while `busy`.
- R12: Mode 2 (index only) never reads memory, even with an indirect prefix held. Only the Y substitution applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | A fetched opcode byte is present this cycle |
| opByte | input | 8 | The fetched opcode byte |
| start | input | 1 | Begin address generation for the current instruction |
| mode | input | 3 | Addressing mode code (see R2) |
| addrHi | input | 8 | High address byte (16-bit modes) |
| addrLo | input | 8 | Low or only address byte |
| idxX | input | 8 | X index register value |
| idxY | input | 8 | Y index register value |
| rdValid | output | 1 | Pointer read request |
| rdAddr | output | 8 | Pointer read address |
| rdReady | input | 1 | Read port accepts the request and drives data |
| rdData | input | 8 | Read data, valid when rdValid and rdReady are both 1 |
| busy | output | 1 | A generation is in progress |
| eaOut | output | 16 | Effective address, valid while eaDone is 1 |
| eaDone | output | 1 | One-cycle completion strobe |
| idxSwap | output | 1 | A held prefix asks for Y in place of X |

## Verification
The assertions assume the following about the inputs. `rdData` is meaningful in the handshake cycle. `mode`, the address bytes and the index values are steady in the cycle `start` is taken. No prefix byte arrives while `busy` is 1, because such a byte would be cleared at `eaDone` along with the old one. The stimulus keeps to these rules. It sends prefix bytes only while the block is idle. It answers reads from a computed byte pattern after a chosen number of stall cycles. It changes the request inputs only together with a `start` pulse, except in one test that pulses `start` while a read is stalled to show that the pulse is ignored.

// File: rtl/eaPkg.sv
package eaPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    MD_ABS8  = 3'd0,
    MD_ABS16 = 3'd1,
    MD_IDX   = 3'd2,
    MD_OFF8  = 3'd3,
    MD_OFF16 = 3'd4
  } eaModeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDA  = 2'd1,
    ST_RDB  = 2'd2,
    ST_FIN  = 2'd3
  } eaStateT;

  typedef struct packed {
    logic capReq;
    logic capHi;
    logic capLo;
    logic rdSel;
    logic indSel;
    logic ySel;
    logic fin;
  } ctlStrobeT;
endpackage

// File: rtl/eaCtrl.sv
module eaCtrl
  import eaPkg::*;
#(
  parameter logic [BYTE_W-1:0] PFX_SWAP = 8'h90,
  parameter logic [BYTE_W-1:0] PFX_BOTH = 8'h91,
  parameter logic [BYTE_W-1:0] PFX_IND  = 8'h92
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [BYTE_W-1:0] opByte,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic              rdReady,
  output logic              busy,
  output logic              rdValid,
  output logic              eaDone,
  output logic              idxSwap,
  output ctlStrobeT         st
);
  eaStateT state, stateNext;
  logic prefY, prefInd, wideR;
  logic isSwap, isBoth, isInd, isPfx;
  logic needRead, wideReq;

  assign isSwap = opValid && (opByte == PFX_SWAP);
  assign isBoth = opValid && (opByte == PFX_BOTH);
  assign isInd  = opValid && (opByte == PFX_IND);
  assign isPfx  = isSwap || isBoth || isInd;

  assign wideReq  = (mode == MD_ABS16) || (mode == MD_OFF16);
  assign needRead = prefInd && (mode != MD_IDX);

  always_comb begin
    st        = '0;
    stateNext = state;
    st.ySel   = prefY;
    st.indSel = needRead;
    case (state)
      ST_IDLE: if (start) begin
        st.capReq = 1'b1;
        stateNext = needRead ? ST_RDA : ST_FIN;
      end
      ST_RDA: if (rdReady) begin
        st.capHi  = wideR;
        st.capLo  = !wideR;
        stateNext = wideR ? ST_RDB : ST_FIN;
      end
      ST_RDB: begin
        st.rdSel = 1'b1;
        if (rdReady) begin
          st.capLo  = 1'b1;
          stateNext = ST_FIN;
        end
      end
      default: begin
        st.fin    = 1'b1;
        stateNext = ST_IDLE;
      end
    endcase
  end

  assign rdValid = (state == ST_RDA) || (state == ST_RDB);
  assign busy    = (state != ST_IDLE);
  assign eaDone  = st.fin;
  assign idxSwap = prefY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wideR <= 1'b0;
    end else begin
      state <= stateNext;
      if (st.capReq) wideR <= wideReq;
    end
  end

  // a new prefix byte wins over the clear at the end of an instruction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prefY   <= 1'b0;
      prefInd <= 1'b0;
    end else if (isPfx) begin
      prefY   <= isSwap || isBoth;
      prefInd <= isInd || isBoth;
    end else if (st.fin) begin
      prefY   <= 1'b0;
      prefInd <= 1'b0;
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    eaDone |=> !eaDone);
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  p_pfx_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eaDone && !isPfx) |=> !idxSwap);
  p_swap_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isSwap || isBoth) |=> idxSwap);
  p_ind_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    isInd |=> !idxSwap);
  p_no_read_idx_r12: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && mode == MD_IDX) |=> !rdValid);
endmodule

// File: rtl/eaPath.sv
module eaPath
  import eaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         st,
  input  logic [2:0]        mode,
  input  logic [BYTE_W-1:0] addrHi,
  input  logic [BYTE_W-1:0] addrLo,
  input  logic [BYTE_W-1:0] idxX,
  input  logic [BYTE_W-1:0] idxY,
  input  logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] eaOut
);
  localparam logic [BYTE_W-1:0] ZERO_B = '0;

  logic [2:0]        modeR;
  logic [BYTE_W-1:0] hiR, loR, idxR, ptrHi, ptrLo;
  logic              indR;
  logic [BYTE_W-1:0] baseHi, baseLo;
  logic [ADDR_W-1:0] idxWide, baseWide, baseShort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR <= '0;
      hiR   <= '0;
      loR   <= '0;
      idxR  <= '0;
      indR  <= 1'b0;
      ptrHi <= '0;
      ptrLo <= '0;
    end else begin
      if (st.capReq) begin
        modeR <= mode;
        hiR   <= addrHi;
        loR   <= addrLo;
        idxR  <= st.ySel ? idxY : idxX;
        indR  <= st.indSel;
        ptrHi <= '0;
        ptrLo <= '0;
      end
      if (st.capHi) ptrHi <= rdData;
      if (st.capLo) ptrLo <= rdData;
    end
  end

  // the second pointer byte sits one above the first, wrapping in 8 bits
  assign rdAddr = st.rdSel ? loR + 8'd1 : loR;

  assign baseHi    = indR ? ptrHi : hiR;
  assign baseLo    = indR ? ptrLo : loR;
  assign idxWide   = {ZERO_B, idxR};
  assign baseWide  = {baseHi, baseLo};
  assign baseShort = {ZERO_B, baseLo};

  always_comb begin
    case (modeR)
      MD_ABS16: eaOut = baseWide;
      MD_IDX:   eaOut = idxWide;
      MD_OFF8:  eaOut = baseShort + idxWide;
      MD_OFF16: eaOut = baseWide + idxWide;
      default:  eaOut = baseShort;
    endcase
  end

  p_off8_max_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.fin && modeR == MD_OFF8) |-> (eaOut <= 16'h01FE));
  p_short_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.fin && modeR == MD_ABS8) |-> (eaOut[ADDR_W-1:BYTE_W] == ZERO_B));
  p_word_next_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.rdSel |-> (rdAddr == loR + 8'd1));
endmodule

// File: rtl/prefixEaGen.sv
module prefixEaGen
  import eaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [7:0]  opByte,
  input  logic        start,
  input  logic [2:0]  mode,
  input  logic [7:0]  addrHi,
  input  logic [7:0]  addrLo,
  input  logic [7:0]  idxX,
  input  logic [7:0]  idxY,
  output logic        rdValid,
  output logic [7:0]  rdAddr,
  input  logic        rdReady,
  input  logic [7:0]  rdData,
  output logic        busy,
  output logic [15:0] eaOut,
  output logic        eaDone,
  output logic        idxSwap
);
  ctlStrobeT st;

  eaCtrl uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte),
    .start(start), .mode(mode), .rdReady(rdReady), .busy(busy),
    .rdValid(rdValid), .eaDone(eaDone), .idxSwap(idxSwap), .st(st)
  );

  eaPath uPath (
    .clk(clk), .rstN(rstN), .st(st), .mode(mode), .addrHi(addrHi),
    .addrLo(addrLo), .idxX(idxX), .idxY(idxY), .rdData(rdData),
    .rdAddr(rdAddr), .eaOut(eaOut)
  );

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdAddr)));
endmodule

// File: tb/sim_prefixEaGen.sv
`timescale 1ns/1ps
module sim_prefixEaGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opByte = '0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  addrHi = '0, addrLo = '0, idxX = '0, idxY = '0;
  logic        rdValid, rdReady = 1'b0;
  logic [7:0]  rdAddr, rdData;
  logic        busy, eaDone, idxSwap;
  logic [15:0] eaOut;
  int          nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [7:0] a);
    logic [7:0] r;
    r = a * 8'd3 + 8'd7;
    return r;
  endfunction

  assign rdData = memByte(rdAddr);

  prefixEaGen u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte),
    .start(start), .mode(mode), .addrHi(addrHi), .addrLo(addrLo),
    .idxX(idxX), .idxY(idxY), .rdValid(rdValid), .rdAddr(rdAddr),
    .rdReady(rdReady), .rdData(rdData), .busy(busy), .eaOut(eaOut),
    .eaDone(eaDone), .idxSwap(idxSwap)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refEa(input logic [2:0] m, input logic [7:0] hi,
      input logic [7:0] lo, input logic [7:0] ix, input bit ind);
    logic [7:0] h, l;
    h = hi; l = lo;
    if (ind && m != 3'd2) begin
      if (m == 3'd1 || m == 3'd4) begin
        h = memByte(lo); l = memByte(lo + 8'd1);
      end else begin
        h = 8'h00; l = memByte(lo);
      end
    end
    case (m)
      3'd1: return {h, l};
      3'd2: return {8'h00, ix};
      3'd3: return {8'h00, l} + {8'h00, ix};
      3'd4: return {h, l} + {8'h00, ix};
      default: return {8'h00, l};
    endcase
  endfunction

  task automatic sendOp(input logic [7:0] b);
    @(negedge clk);
    opValid = 1'b1; opByte = b;
    @(negedge clk);
    opValid = 1'b0; opByte = '0;
  endtask

  // one address generation; checks result, timing, reads and done pulse
  task automatic runEa(input logic [2:0] m, input logic [7:0] hi, input logic [7:0] lo,
      input logic [7:0] x, input logic [7:0] y, input bit useY, input bit useInd,
      input int stall, input bit inject, input string tag);
    int cyc, nR, stallLeft, expR, expCyc;
    bit stalledPrev;
    logic [7:0] prevAddr;
    logic [7:0] rdA [2];
    logic [15:0] expEa;
    bit wide;
    wide = (m == 3'd1 || m == 3'd4);
    expR = (useInd && m != 3'd2) ? (wide ? 2 : 1) : 0;
    expCyc = 1 + expR * (stall + 1);
    expEa = refEa(m, hi, lo, useY ? y : x, useInd);
    rdA[0] = '0; rdA[1] = '0;
    @(negedge clk);
    mode = m; addrHi = hi; addrLo = lo; idxX = x; idxY = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; nR = 0; stallLeft = stall; stalledPrev = 0; prevAddr = '0;
    while (!eaDone && cyc < 40) begin
      if (inject && cyc == 1) begin start = 1'b1; mode = 3'd0; addrLo = 8'hEE; end
      else if (inject && cyc == 2) start = 1'b0;
      if (stalledPrev)
        check(rdValid && rdAddr == prevAddr, {tag, " R10 hold"}, rdAddr, prevAddr);
      rdReady = 1'b0; stalledPrev = 0;
      if (rdValid) begin
        if (stallLeft > 0) begin
          stallLeft--; stalledPrev = 1; prevAddr = rdAddr;
        end else begin
          rdReady = 1'b1;
          if (nR < 2) rdA[nR] = rdAddr;
          nR++; stallLeft = stall;
        end
      end
      @(negedge clk);
      cyc++;
    end
    rdReady = 1'b0; start = 1'b0;
    check(eaDone == 1'b1, {tag, " R11 done seen"}, eaDone, 1);
    check(eaOut == expEa, {tag, " ea"}, eaOut, expEa);
    check(cyc == expCyc, {tag, " R2 latency"}, cyc, expCyc);
    check(nR == expR, {tag, " R12 read count"}, nR, expR);
    if (expR >= 1) check(rdA[0] == lo, {tag, " R5 first read addr"}, rdA[0], lo);
    if (expR == 2) check(rdA[1] == lo + 8'd1, {tag, " R6 second read addr"}, rdA[1], lo + 8'd1);
    @(negedge clk);
    check(!eaDone && !busy, {tag, " R11 single pulse"}, {eaDone, busy}, 0);
    check(!idxSwap, {tag, " R9 prefix cleared"}, idxSwap, 0);
  endtask

  task automatic tReset;
    check(!busy && !eaDone && !rdValid && !idxSwap, "R1 reset outputs",
          {busy, eaDone, rdValid, idxSwap}, 0);
  endtask

  task automatic tDirect;
    runEa(3'd0, 8'hAA, 8'h34, 8'h11, 8'h22, 0, 0, 0, 0, "R2 abs8");
    runEa(3'd1, 8'h12, 8'h34, 8'h11, 8'h22, 0, 0, 0, 0, "R2 abs16");
    runEa(3'd2, 8'h12, 8'h34, 8'h77, 8'h22, 0, 0, 0, 0, "R2 index only");
    runEa(3'd6, 8'h12, 8'h9C, 8'h77, 8'h22, 0, 0, 0, 0, "R2 spare code");
    runEa(3'd3, 8'h00, 8'hFF, 8'hFF, 8'h01, 0, 0, 0, 0, "R3 off8 max");
    runEa(3'd4, 8'hFF, 8'hF0, 8'h20, 8'h01, 0, 0, 0, 0, "R3 off16 wrap");
  endtask

  task automatic tSwap;
    sendOp(8'h90);
    check(idxSwap, "R4 swap flag", idxSwap, 1);
    runEa(3'd3, 8'h00, 8'h10, 8'h01, 8'h40, 1, 0, 0, 0, "R4 y index");
    runEa(3'd3, 8'h00, 8'h10, 8'h01, 8'h40, 0, 0, 0, 0, "R9 back to x");
  endtask

  task automatic tIndirect;
    sendOp(8'h92);
    check(!idxSwap, "R5 no swap", idxSwap, 0);
    runEa(3'd3, 8'h00, 8'h20, 8'h05, 8'h09, 0, 1, 2, 0, "R5 byte ptr off8");
    sendOp(8'h92);
    runEa(3'd0, 8'h55, 8'h81, 8'h05, 8'h09, 0, 1, 0, 0, "R5 byte ptr abs8");
    sendOp(8'h92);
    runEa(3'd1, 8'h00, 8'hFF, 8'h05, 8'h09, 0, 1, 1, 0, "R6 word ptr wrap");
    sendOp(8'h92);
    runEa(3'd4, 8'h33, 8'h40, 8'hF3, 8'h09, 0, 1, 0, 0, "R6 word ptr off16");
    runEa(3'd1, 8'h33, 8'h40, 8'hF3, 8'h09, 0, 0, 0, 0, "R9 direct again");
  endtask

  task automatic tBoth;
    sendOp(8'h91);
    check(idxSwap, "R7 swap flag", idxSwap, 1);
    runEa(3'd4, 8'h00, 8'h30, 8'h02, 8'hC4, 1, 1, 1, 0, "R7 y and word ptr");
  endtask

  task automatic tReplace;
    sendOp(8'h92);
    sendOp(8'h90);
    runEa(3'd3, 8'h00, 8'h50, 8'h02, 8'h0B, 1, 0, 0, 0, "R8 later swap wins");
    sendOp(8'h90);
    sendOp(8'h92);
    check(!idxSwap, "R8 later ind wins", idxSwap, 0);
    runEa(3'd3, 8'h00, 8'h50, 8'h02, 8'h0B, 0, 1, 0, 0, "R8 ind only");
  endtask

  task automatic tIdxOnly;
    sendOp(8'h91);
    runEa(3'd2, 8'h12, 8'h34, 8'h02, 8'h6D, 1, 1, 0, 0, "R12 idx no read");
  endtask

  task automatic tBusy;
    sendOp(8'h92);
    runEa(3'd3, 8'h00, 8'h61, 8'h03, 8'h09, 0, 1, 2, 1, "R11 start while busy");
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDirect();
    tSwap();
    tIndirect();
    tBoth();
    tReplace();
    tIdxOnly();
    tBusy();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule